// File: doc/BRIEF.md
# Program Counter and Return-Address Stack

This block keeps the instruction address of a small 4-bit processor and the return addresses of its subroutine calls. Each cycle the sequencer raises at most one control strobe: advance by one or two bytes after a fetch, take an absolute 12-bit jump, call a subroutine, return, or take a page-relative indirect jump. The return-address stack holds up to three entries. When a call is made with the stack full, the oldest entry is discarded and no error is raised.

Indirect jumps and indirect fetches share one address form. The upper four bits come from the address that follows the current instruction (PC+1), not from the PC itself. The low eight bits come from a register-pair value. That address is always present on its own output, so the fetch path can read through it without moving the PC.

Top module: `pc_stack_unit`

## Requirements
- R1: While rst_ni is low, pc_o is 0 and depth_o is 0, without waiting for a clock edge.
- R2: With inc_i alone, pc_o advances by 1 at the next edge, or by 2 when two_byte_i is high. The result wraps modulo 4096, so 0xFFF+1 gives 0x000 and 0xFFE+2 gives 0x000.
- R3: With jump_i, pc_o takes target_i at the next edge and depth_o is unchanged.
- R4: With call_i, pc_o takes target_i, the value pc_o+2 is pushed, and depth_o rises by one.
- R5: A call made when depth_o is 3 leaves depth_o at 3 and discards the oldest stacked address. The two newest addresses and the new one are kept in LIFO order.
- R6: With ret_i and depth_o above 0, pc_o takes the most recently pushed address and depth_o falls by one.
- R7: With ret_i and depth_o equal to 0, pc_o becomes pc_o+1 and depth_o stays 0.
- R8: With jind_i, pc_o becomes {bits 11:8 of pc_o+1, pair_i}.
- R9: ind_addr_o always equals {bits 11:8 of pc_o+1, pair_i}, computed combinationally.
- R10: When several strobes are high in one cycle, only one acts, in this order of priority: ret_i, call_i, jump_i, jind_i, inc_i.
- R11: With no strobe high, pc_o and depth_o hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inc_i | input | 1 | Advance the PC after a fetch |
| two_byte_i | input | 1 | Advance by two bytes instead of one |
| jump_i | input | 1 | Absolute jump to target_i |
| call_i | input | 1 | Subroutine call to target_i |
| ret_i | input | 1 | Return from subroutine |
| jind_i | input | 1 | Page-relative indirect jump |
| target_i | input | 12 | Absolute jump or call target |
| pair_i | input | 8 | Register-pair value used as the low address byte |
| pc_o | output | 12 | Current program counter |
| depth_o | output | 2 | Number of stacked return addresses |
| ind_addr_o | output | 12 | Page-relative indirect address |

## Verification
Return, call, jump, indirect jump and increment can all be strobed in the same cycle. The most telling collision is a return against a call, because both act on the stack.

The bench raises every strobe together while the stack is empty. It then raises call together with jump and increment, and raises return together with call while one entry is stacked. In each case it judges the result by the next pc_o and depth_o: only the strobe with the highest priority may have acted, and no push may occur alongside a pop.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned PAIR_W  = 8;
  localparam int unsigned PAGE_W  = ADDR_W - PAIR_W;
  localparam int unsigned STACK_N = 3;

  typedef logic [ADDR_W-1:0] addr_t;

  typedef struct packed {
    logic inc;
    logic two;
    logic jump;
    logic call;
    logic ret;
    logic jind;
  } pcs_ctrl_t;
endpackage

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
  parameter int unsigned N      = pcs_pkg::STACK_N,
  parameter int unsigned W      = pcs_pkg::ADDR_W,
  localparam int unsigned DEP_W = $clog2(N + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [W-1:0]     data_i,
  output logic [W-1:0]     top_o,
  output logic             empty_o,
  output logic [DEP_W-1:0] depth_o
);
  // slot 0 is the top; a push shifts down and the bottom slot falls off
  logic [W-1:0]     slot_q [N];
  logic [DEP_W-1:0] depth_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q[0] <= '0;
    else if (push_i) slot_q[0] <= data_i;
    else if (pop_i)  slot_q[0] <= (N > 1) ? slot_q[1 % N] : '0;
  end

  for (genvar k = 1; k < N; k++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q[k] <= '0;
      else if (push_i) slot_q[k] <= slot_q[k-1];
      else if (pop_i)  slot_q[k] <= (k + 1 < N) ? slot_q[(k+1) % N] : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) depth_q <= '0;
    else if (push_i && depth_q != DEP_W'(N)) depth_q <= depth_q + 1'b1;
    else if (pop_i && depth_q != '0)         depth_q <= depth_q - 1'b1;
  end

  assign top_o   = slot_q[0];
  assign empty_o = (depth_q == '0);
  assign depth_o = depth_q;
endmodule

// File: rtl/pcs_next_pc.sv
module pcs_next_pc
  import pcs_pkg::*;
(
  input  addr_t              pc_i,
  input  pcs_ctrl_t          ctrl_i,
  input  addr_t              target_i,
  input  logic [PAIR_W-1:0]  pair_i,
  input  addr_t              top_i,
  input  logic               empty_i,
  output addr_t              nxt_o,
  output logic               push_o,
  output logic               pop_o,
  output addr_t              push_data_o,
  output addr_t              ind_addr_o
);
  addr_t plus1, plus2;

  assign plus1       = pc_i + ADDR_W'(1);
  assign plus2       = pc_i + ADDR_W'(2);
  assign ind_addr_o  = {plus1[ADDR_W-1 -: PAGE_W], pair_i};
  assign push_data_o = plus2;

  always_comb begin
    nxt_o  = pc_i;
    push_o = 1'b0;
    pop_o  = 1'b0;
    if (ctrl_i.ret) begin
      if (!empty_i) begin
        nxt_o = top_i;
        pop_o = 1'b1;
      end else begin
        nxt_o = plus1;
      end
    end else if (ctrl_i.call) begin
      nxt_o  = target_i;
      push_o = 1'b1;
    end else if (ctrl_i.jump) begin
      nxt_o = target_i;
    end else if (ctrl_i.jind) begin
      nxt_o = ind_addr_o;
    end else if (ctrl_i.inc) begin
      nxt_o = ctrl_i.two ? plus2 : plus1;
    end
  end
endmodule

// File: rtl/pc_stack_unit.sv
module pc_stack_unit
  import pcs_pkg::*;
#(
  parameter int unsigned STACK_N = pcs_pkg::STACK_N,
  localparam int unsigned DEP_W  = $clog2(STACK_N + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              two_byte_i,
  input  logic              jump_i,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              jind_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic [PAIR_W-1:0] pair_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DEP_W-1:0]  depth_o,
  output logic [ADDR_W-1:0] ind_addr_o
);
  pcs_ctrl_t ctrl;
  addr_t     pc_q, pc_d, top, push_data;
  logic      push, pop, empty;

  assign ctrl = '{inc: inc_i, two: two_byte_i, jump: jump_i,
                  call: call_i, ret: ret_i, jind: jind_i};

  pcs_next_pc i_next (
    .pc_i       (pc_q),
    .ctrl_i     (ctrl),
    .target_i   (target_i),
    .pair_i     (pair_i),
    .top_i      (top),
    .empty_i    (empty),
    .nxt_o      (pc_d),
    .push_o     (push),
    .pop_o      (pop),
    .push_data_o(push_data),
    .ind_addr_o (ind_addr_o)
  );

  pcs_ret_stack #(.N(STACK_N), .W(ADDR_W)) i_stack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .pop_i  (pop),
    .data_i (push_data),
    .top_o  (top),
    .empty_o(empty),
    .depth_o(depth_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/pc_stack_chk.sv
module pc_stack_chk #(
  parameter int unsigned STACK_N = 3,
  parameter int unsigned DEP_W   = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             inc_i,
  input logic             two_byte_i,
  input logic             jump_i,
  input logic             call_i,
  input logic             ret_i,
  input logic             jind_i,
  input logic [11:0]      target_i,
  input logic [7:0]       pair_i,
  input logic [11:0]      pc_o,
  input logic [DEP_W-1:0] depth_o,
  input logic [11:0]      ind_addr_o
);
  logic [11:0] nxt1;
  assign nxt1 = pc_o + 12'd1;

  a_r1_reset_state: assert property (@(posedge clk_i)
    !rst_ni |-> (pc_o == '0 && depth_o == '0));

  a_r3_jump_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jump_i && !ret_i && !call_i) |=> (pc_o == $past(target_i) && $stable(depth_o)));

  a_r4_call_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !ret_i && depth_o != DEP_W'(STACK_N))
      |=> (pc_o == $past(target_i) && depth_o == $past(depth_o) + 1'b1));

  a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !ret_i && depth_o == DEP_W'(STACK_N)) |=> depth_o == DEP_W'(STACK_N));

  a_r6_pop_depth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && depth_o != '0) |=> depth_o == $past(depth_o) - 1'b1);

  a_r7_empty_ret: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && depth_o == '0) |=> (depth_o == '0 && pc_o == $past(nxt1)));

  a_r9_ind_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ind_addr_o == {nxt1[11:8], pair_i});

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inc_i || jump_i || call_i || ret_i || jind_i) |=> ($stable(pc_o) && $stable(depth_o)));

  a_r5_depth_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_o <= DEP_W'(STACK_N));
endmodule

bind pc_stack_unit pc_stack_chk #(.STACK_N(STACK_N), .DEP_W(DEP_W)) i_pc_stack_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(inc_i), .two_byte_i(two_byte_i),
  .jump_i(jump_i), .call_i(call_i), .ret_i(ret_i), .jind_i(jind_i),
  .target_i(target_i), .pair_i(pair_i), .pc_o(pc_o), .depth_o(depth_o),
  .ind_addr_o(ind_addr_o)
);

// File: tb/test_pc_stack_unit.sv
module test_pc_stack_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        inc_i = 0, two_byte_i = 0, jump_i = 0, call_i = 0, ret_i = 0, jind_i = 0;
  logic [11:0] target_i = '0;
  logic [7:0]  pair_i = '0;
  logic [11:0] pc_o, ind_addr_o;
  logic [1:0]  depth_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  pc_stack_unit i_pc_stack_unit (.*);

  typedef struct packed {
    logic r, c, j, ji, i, two;
    logic [11:0] tgt;
    logic [7:0]  pr;
    logic [11:0] epc;
    logic [1:0]  edep;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t TBL [NV] = '{
    '{0,0,0,0,1,0, 12'h000, 8'h00, 12'h001, 2'd0, 4'd2},  // R2 inc by 1
    '{0,0,0,0,1,1, 12'h000, 8'h00, 12'h003, 2'd0, 4'd2},  // R2 inc by 2
    '{0,0,1,0,0,0, 12'h120, 8'h00, 12'h120, 2'd0, 4'd3},  // R3
    '{0,1,0,0,0,0, 12'h200, 8'h00, 12'h200, 2'd1, 4'd4},  // R4 push 122
    '{0,1,0,0,0,0, 12'h300, 8'h00, 12'h300, 2'd2, 4'd4},  // R4 push 202
    '{0,1,0,0,0,0, 12'h400, 8'h00, 12'h400, 2'd3, 4'd4},  // R4 push 302
    '{0,1,0,0,0,0, 12'h500, 8'h00, 12'h500, 2'd3, 4'd5},  // R5 push 402, drop 122
    '{1,0,0,0,0,0, 12'h000, 8'h00, 12'h402, 2'd2, 4'd6},  // R6
    '{1,0,0,0,0,0, 12'h000, 8'h00, 12'h302, 2'd1, 4'd6},  // R6
    '{1,0,0,0,0,0, 12'h000, 8'h00, 12'h202, 2'd0, 4'd5},  // R5 oldest 122 gone
    '{1,0,0,0,0,0, 12'h000, 8'h00, 12'h203, 2'd0, 4'd7},  // R7
    '{0,0,0,1,0,0, 12'h000, 8'h5A, 12'h25A, 2'd0, 4'd8},  // R8
    '{0,0,1,0,0,0, 12'h0FF, 8'h00, 12'h0FF, 2'd0, 4'd3},  // R3
    '{0,0,0,1,0,0, 12'h000, 8'h10, 12'h110, 2'd0, 4'd8},  // R8 page from PC+1
    '{1,1,1,1,1,1, 12'h800, 8'h44, 12'h111, 2'd0, 4'd10}, // R10 ret wins, empty
    '{0,1,1,0,1,0, 12'h7AB, 8'h00, 12'h7AB, 2'd1, 4'd10}, // R10 call wins, push 113
    '{0,0,1,1,1,0, 12'h050, 8'hEE, 12'h050, 2'd1, 4'd10}, // R10 jump wins
    '{0,0,0,1,1,1, 12'h000, 8'h33, 12'h033, 2'd1, 4'd10}, // R10 jind wins
    '{1,1,0,0,0,0, 12'h999, 8'h00, 12'h113, 2'd0, 4'd10}, // R10 ret beats call
    '{0,0,1,0,0,0, 12'hFFF, 8'h00, 12'hFFF, 2'd0, 4'd3},  // R3
    '{0,0,0,0,1,0, 12'h000, 8'h00, 12'h000, 2'd0, 4'd2},  // R2 wrap
    '{0,0,1,0,0,0, 12'hFFE, 8'h00, 12'hFFE, 2'd0, 4'd3},  // R3
    '{0,0,0,0,1,1, 12'h000, 8'h00, 12'h000, 2'd0, 4'd2},  // R2 wrap by 2
    '{0,0,0,0,0,0, 12'h5A5, 8'h00, 12'h000, 2'd0, 4'd11}, // R11 hold
    '{0,0,0,1,0,0, 12'h000, 8'h77, 12'h077, 2'd0, 4'd8}   // R8
  };

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    ret_i = v.r; call_i = v.c; jump_i = v.j; jind_i = v.ji; inc_i = v.i;
    two_byte_i = v.two; target_i = v.tgt; pair_i = v.pr;
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    #1;
    check("R1 pc", pc_o, 12'h000);
    check("R1 depth", 12'(depth_o), 12'h000);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int k = 0; k < NV; k++) begin
      @(negedge clk_i);
      drive(TBL[k]);
      @(posedge clk_i);
      #1;
      check($sformatf("R%0d pc vec %0d", TBL[k].req, k), pc_o, TBL[k].epc);
      check($sformatf("R%0d depth vec %0d", TBL[k].req, k), 12'(depth_o), 12'(TBL[k].edep));
    end
    // R9: indirect address follows pair_i and page of PC+1 with no clock edge
    @(negedge clk_i);
    drive('0);
    pair_i = 8'hC3;
    #1 check("R9 ind_addr", ind_addr_o, 12'h0C3);
    @(negedge clk_i);
    target_i = 12'h2FF; jump_i = 1'b1;
    @(negedge clk_i);
    jump_i = 1'b0; pair_i = 8'h9E;
    #1 check("R9 ind_addr page cross", ind_addr_o, 12'h39E);
    check("R11 pc held with pair change", pc_o, 12'h2FF);
    // R1: asynchronous reset mid-run with stacked entry
    call_i = 1'b1; target_i = 12'h444;
    @(negedge clk_i);
    call_i = 1'b0;
    check("R4 depth before reset", 12'(depth_o), 12'h001);
    #2 rst_ni = 1'b0;
    #1;
    check("R1 async pc", pc_o, 12'h000);
    check("R1 async depth", 12'(depth_o), 12'h000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    ret_i = 1'b1;
    @(posedge clk_i);
    #1 check("R7 empty after reset", pc_o, 12'h001);
    ret_i = 1'b0;
    done = 1;
    finish_run();
  end
endmodule